// File: doc/BRIEF.md
# External Interrupt Conditioner

This block sits between six external interrupt request pins, one non-maskable interrupt (NMI) pin and a CPU's interrupt logic. Every pin is first brought into the clock domain by a two-flop synchronizer. Each request pin then has its own trigger type: rising edge, falling edge, low level or high level. An edge-triggered pin latches a sticky pending flag that software clears by writing 1 to it. A level-triggered pin drives its output straight from the synchronized pin state.

Request pins 3..0 can be regrouped into one 4-bit active-low priority code carrying 15 levels. The code is reported only after it has held steady for two consecutive clocks. Three control bits set the masking. One masks every request while the NMI pin is low. One selects the grouped mode. One lets NMI through even when the CPU block bit is set. Standby always masks NMI.

Configuration goes through a plain single-cycle register write/read port. There is no streaming data path, so no port uses valid/ready. Every pin is a plain control or status signal with no back-pressure. The read data is combinational from the address.

Top module: `eirq_cond`

## Requirements
- R1: After reset, the control register (address 0) reads 0x4000, the trigger-type register (address 1) reads 0x0000, and all pending outputs and `nmi_accept` are 0.
- R2: A level-triggered request output reflects a pin change after exactly two rising clock edges, and not after one.
- R3: The trigger type for pin i sits in bits [2i+1:2i] of address 1: 00 falling edge, 01 rising edge, 10 low level, 11 high level. A matching edge sets a sticky pending flag that is visible on the third clock edge after the pin change. The flag stays set after the pin returns, and the opposite edge does not clear it.
- R4: Control bits 15 (mask-all), 14 (grouped mode) and 13 (NMI unblock) are read back as written. Bit 12 and all other control bits read 0 whatever was written.
- R5: Address 2 reads the six sticky flags in bits 5..0. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R6: When control bit 15 is 1 and the synchronized NMI pin is 0, `irq_pend` is all zero and `irq_lvl_vld` is 0. When bit 15 is 0, the NMI pin level has no effect on requests.
- R7: When control bit 14 is 1, `irq_pend[3:0]` is 0 and the code is the bitwise inverse of pins 3..0. All pins high (code 0) means no request. Pins 4 and 5 keep their independent behaviour in both modes.
- R8: `irq_lvl_vld` is 1 only when a nonzero code has been identical for two consecutive clocks. It rises on the third edge after a code change. `irq_lvl` is 0 whenever `irq_lvl_vld` is 0.
- R9: `nmi_accept` is 1 when the synchronized NMI pin is 1, unless the CPU block bit is 1 while control bit 13 is 0.
- R10: `nmi_accept` is 0 whenever `standby` is 1, whatever the control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 trigger type, 2 pending flags) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq_pin | input | 6 | External request pins |
| nmi_pin | input | 1 | NMI pin, active high |
| cpu_block | input | 1 | CPU block bit |
| standby | input | 1 | Standby indication |
| irq_pend | output | 6 | Per-pin request outputs after masking |
| irq_lvl | output | 4 | Grouped priority code, 0 when not valid |
| irq_lvl_vld | output | 1 | Grouped code is stable and nonzero |
| nmi_accept | output | 1 | NMI is accepted |

## Verification
The bench samples a level-triggered pin and the grouped code exactly one edge before and at the edge where each should change. A synchronizer that is one stage short, or a stability filter that is missing, would show up one cycle early. It checks that the opposite edge neither sets nor clears a sticky flag. It also checks that a write-1 clear removes only the addressed flag, so a flag that followed the pin or a clear of the whole register would fail. Random trials cover all four trigger types under every combination of grouped mode, mask-all and NMI gating. Here an inverted mask polarity, a grouped mode that leaks pins 3..0 or drops pins 4 and 5, or standby failing to block NMI would each produce wrong outputs.

// File: rtl/eirq_pkg.sv
`timescale 1ns/1ps
package eirq_pkg;
  typedef enum logic [1:0] {
    TRIG_FALL = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_HIGH = 2'b11
  } trig_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TRIG = 2'd1;
  localparam logic [1:0] ADDR_PEND = 2'd2;

  localparam int CTRL_MASKALL = 15;
  localparam int CTRL_GROUP   = 14;
  localparam int CTRL_UNBLOCK = 13;
  localparam int CTRL_RSVD    = 12;
endpackage

// File: rtl/eirq_sync.sv
`timescale 1ns/1ps
module eirq_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= din;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/eirq_pin_det.sv
`timescale 1ns/1ps
module eirq_pin_det
  import eirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_s,
  input  logic [1:0] trig,
  input  logic       clr,
  output logic       req,
  output logic       flag
);
  logic prev_q;
  logic edge_hit;

  always_comb begin
    case (trig_e'(trig))
      TRIG_RISE: edge_hit = pin_s & ~prev_q;
      TRIG_FALL: edge_hit = ~pin_s & prev_q;
      default:   edge_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag   <= 1'b0;
    end else begin
      prev_q <= pin_s;
      flag   <= edge_hit | (flag & ~clr);
    end
  end

  assign req = trig[1] ? (trig[0] ? pin_s : ~pin_s) : flag;
endmodule

// File: rtl/eirq_lvl_enc.sv
`timescale 1ns/1ps
module eirq_lvl_enc #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] pins_s,
  output logic [W-1:0] lvl,
  output logic         vld
);
  logic [W-1:0] code;
  logic [W-1:0] code_q;

  assign code = en ? ~pins_s : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code;
  end

  assign vld = (code != '0) && (code == code_q);
  assign lvl = vld ? code : '0;
endmodule

// File: rtl/eirq_cond.sv
`timescale 1ns/1ps
module eirq_cond
  import eirq_pkg::*;
#(
  parameter int N_IRQ  = 6,
  parameter int LVL_W  = 4,
  parameter int DATA_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_IRQ-1:0]  irq_pin,
  input  logic              nmi_pin,
  input  logic              cpu_block,
  input  logic              standby,
  output logic [N_IRQ-1:0]  irq_pend,
  output logic [LVL_W-1:0]  irq_lvl,
  output logic              irq_lvl_vld,
  output logic              nmi_accept
);
  localparam int TRIG_W = 2 * N_IRQ;

  logic              mask_all_q, group_q, unblock_q;
  logic [TRIG_W-1:0] trig_q;
  logic [N_IRQ-1:0]  clr_vec, req_vec, flag_vec;
  logic [N_IRQ:0]    sync_out;
  logic [N_IRQ-1:0]  irq_s;
  logic              nmi_s;
  logic              all_masked;
  logic [LVL_W-1:0]  lvl_raw;
  logic              lvl_vld_raw;
  logic              unused_wd;

  assign unused_wd = reg_wdata[CTRL_RSVD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_all_q <= 1'b0;
      group_q    <= 1'b1;
      unblock_q  <= 1'b0;
      trig_q     <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_CTRL) begin
        mask_all_q <= reg_wdata[CTRL_MASKALL];
        group_q    <= reg_wdata[CTRL_GROUP];
        unblock_q  <= reg_wdata[CTRL_UNBLOCK];
      end
      if (reg_addr == ADDR_TRIG) trig_q <= reg_wdata[TRIG_W-1:0];
    end
  end

  assign clr_vec = (reg_wr && reg_addr == ADDR_PEND) ? reg_wdata[N_IRQ-1:0] : '0;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[CTRL_MASKALL] = mask_all_q;
        reg_rdata[CTRL_GROUP]   = group_q;
        reg_rdata[CTRL_UNBLOCK] = unblock_q;
      end
      ADDR_TRIG: reg_rdata[TRIG_W-1:0] = trig_q;
      ADDR_PEND: reg_rdata[N_IRQ-1:0]  = flag_vec;
      default:   reg_rdata = '0;
    endcase
  end

  eirq_sync #(.W(N_IRQ + 1), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({nmi_pin, irq_pin}), .dout(sync_out)
  );
  assign irq_s = sync_out[N_IRQ-1:0];
  assign nmi_s = sync_out[N_IRQ];

  for (genvar i = 0; i < N_IRQ; i++) begin : g_pin
    eirq_pin_det u_det (
      .clk(clk), .rst_n(rst_n), .pin_s(irq_s[i]),
      .trig(trig_q[2*i+1:2*i]), .clr(clr_vec[i]),
      .req(req_vec[i]), .flag(flag_vec[i])
    );
  end

  eirq_lvl_enc #(.W(LVL_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .en(group_q), .pins_s(irq_s[LVL_W-1:0]),
    .lvl(lvl_raw), .vld(lvl_vld_raw)
  );

  assign all_masked = mask_all_q & ~nmi_s;

  always_comb begin
    irq_pend = req_vec;
    if (group_q) irq_pend[LVL_W-1:0] = '0;
    if (all_masked) irq_pend = '0;
  end

  assign irq_lvl_vld = lvl_vld_raw & ~all_masked;
  assign irq_lvl     = irq_lvl_vld ? lvl_raw : '0;
  assign nmi_accept  = nmi_s & ~standby & ~(cpu_block & ~unblock_q);
endmodule

// File: rtl/eirq_cond_chk.sv
`timescale 1ns/1ps
module eirq_cond_chk #(
  parameter int N_IRQ = 6,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       reg_addr,
  input logic [15:0]      reg_rdata,
  input logic             cpu_block,
  input logic             standby,
  input logic [N_IRQ-1:0] irq_pend,
  input logic [LVL_W-1:0] irq_lvl,
  input logic             irq_lvl_vld,
  input logic             nmi_accept,
  input logic             mask_all_q,
  input logic             group_q,
  input logic             unblock_q,
  input logic             nmi_s
);
  a_r4_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[12:0] == 13'd0));

  a_r6_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_all_q && !nmi_s) |-> (irq_pend == '0 && !irq_lvl_vld));

  a_r7_group_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    group_q |-> (irq_pend[LVL_W-1:0] == '0));

  a_r7_indep_no_code: assert property (@(posedge clk) disable iff (!rst_n)
    !group_q |-> !irq_lvl_vld);

  a_r8_code_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lvl_vld |-> (irq_lvl != '0));

  a_r8_code_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_lvl_vld |-> (irq_lvl == '0));

  a_r8_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl_vld && $past(irq_lvl_vld)) |-> $stable(irq_lvl));

  a_r9_block: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_block && !unblock_q) |-> !nmi_accept);

  a_r10_standby: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !nmi_accept);
endmodule

bind eirq_cond eirq_cond_chk #(.N_IRQ(N_IRQ), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .cpu_block(cpu_block), .standby(standby), .irq_pend(irq_pend),
  .irq_lvl(irq_lvl), .irq_lvl_vld(irq_lvl_vld), .nmi_accept(nmi_accept),
  .mask_all_q(mask_all_q), .group_q(group_q), .unblock_q(unblock_q),
  .nmi_s(nmi_s)
);

// File: tb/test_eirq_cond.sv
`timescale 1ns/1ps
module test_eirq_cond;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [5:0]  irq_pin = 6'h3F;
  logic        nmi_pin = 1'b0;
  logic        cpu_block = 1'b0;
  logic        standby = 1'b0;
  logic [5:0]  irq_pend;
  logic [3:0]  irq_lvl;
  logic        irq_lvl_vld;
  logic        nmi_accept;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  eirq_cond i_eirq_cond (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pin(irq_pin),
    .nmi_pin(nmi_pin), .cpu_block(cpu_block), .standby(standby),
    .irq_pend(irq_pend), .irq_lvl(irq_lvl), .irq_lvl_vld(irq_lvl_vld),
    .nmi_accept(nmi_accept)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [5:0] exp_pend(input logic [15:0] ctrl, input logic [11:0] trig,
                                          input logic [5:0] oldp, input logic [5:0] newp,
                                          input logic nmi);
    logic [5:0] r;
    for (int i = 0; i < 6; i++) begin
      case (trig[2*i +: 2])
        2'b00: r[i] = oldp[i] & ~newp[i];
        2'b01: r[i] = ~oldp[i] & newp[i];
        2'b10: r[i] = ~newp[i];
        default: r[i] = newp[i];
      endcase
    end
    if (ctrl[14]) r[3:0] = 4'b0;
    if (ctrl[15] && !nmi) r = 6'b0;
    return r;
  endfunction

  function automatic logic [4:0] exp_code(input logic [15:0] ctrl, input logic [5:0] newp,
                                          input logic nmi);
    logic [3:0] c;
    c = ctrl[14] ? ~newp[3:0] : 4'b0;
    if (c == 4'b0 || (ctrl[15] && !nmi)) return 5'b0;
    return {1'b1, c};
  endfunction

  function automatic logic exp_nmi(input logic [15:0] ctrl, input logic nmi,
                                   input logic blk, input logic stby);
    return nmi & ~stby & ~(blk & ~ctrl[13]);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] ctrl;
    logic [11:0] trig;
    logic [5:0]  oldp, newp;
    logic [4:0]  ec;
    void'($urandom(32'd20240613));

    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    rd_chk("R1 ctrl reset", 2'd0, 16'h4000);
    rd_chk("R1 trig reset", 2'd1, 16'h0000);
    chk("R1 pend reset", {10'b0, irq_pend}, 16'h0);
    chk("R1 nmi reset", {15'b0, nmi_accept}, 16'h0);

    // R4 reserved bit and readback
    wr(2'd0, 16'hFFFF);
    rd_chk("R4 ctrl all ones", 2'd0, 16'hE000);
    wr(2'd0, 16'h1000);
    rd_chk("R4 rsvd only", 2'd0, 16'h0000);

    // R2 level latency: pin0 high level, independent mode
    wr(2'd1, 16'h0003);
    irq_pin = 6'h00;
    wait_n(4);
    irq_pin[0] = 1'b1;
    wait_n(1);
    chk("R2 one edge", {15'b0, irq_pend[0]}, 16'h0);
    wait_n(1);
    chk("R2 two edges", {15'b0, irq_pend[0]}, 16'h1);

    // R3 rising edge on pin1 sticky
    wr(2'd1, 16'h0004);
    wr(2'd2, 16'h003F);
    irq_pin[1] = 1'b1;
    wait_n(2);
    chk("R3 edge two clocks", {15'b0, irq_pend[1]}, 16'h0);
    wait_n(1);
    chk("R3 edge three clocks", {15'b0, irq_pend[1]}, 16'h1);
    irq_pin[1] = 1'b0;
    wait_n(4);
    chk("R3 sticky after fall", {15'b0, irq_pend[1]}, 16'h1);

    // R5 write-1 clear, write-0 keeps
    wr(2'd1, 16'h0005);
    irq_pin[0] = 1'b0;
    wait_n(3);
    irq_pin[0] = 1'b1;
    wait_n(4);
    rd_chk("R5 both set", 2'd2, 16'h0003);
    wr(2'd2, 16'h0000);
    rd_chk("R5 write0 keeps", 2'd2, 16'h0003);
    wr(2'd2, 16'h0002);
    rd_chk("R5 clear one", 2'd2, 16'h0001);
    chk("R5 pend out", {10'b0, irq_pend}, 16'h0001);

    // R6 mask-all gated by NMI pin level
    wr(2'd1, 16'h0003);
    wr(2'd0, 16'h8000);
    nmi_pin = 1'b0;
    wait_n(4);
    chk("R6 masked", {10'b0, irq_pend}, 16'h0);
    nmi_pin = 1'b1;
    wait_n(4);
    chk("R6 nmi high unmasks", {10'b0, irq_pend}, 16'h0001);

    // R7/R8 grouped mode
    wr(2'd0, 16'h4000);
    wr(2'd1, 16'h0300);
    irq_pin = 6'h1F;
    wait_n(4);
    chk("R7 all high no code", {11'b0, irq_lvl_vld, irq_lvl}, 16'h0);
    chk("R7 pin4 independent", {10'b0, irq_pend}, 16'h0010);
    irq_pin[3:0] = 4'b1010;
    wait_n(2);
    chk("R8 not yet stable", {11'b0, irq_lvl_vld, irq_lvl}, 16'h0);
    wait_n(1);
    chk("R8 stable code", {11'b0, irq_lvl_vld, irq_lvl}, 16'h0015);

    // R9/R10 NMI gating
    wr(2'd0, 16'h0000);
    nmi_pin = 1'b1; cpu_block = 1'b1; standby = 1'b0;
    wait_n(3);
    chk("R9 blocked", {15'b0, nmi_accept}, 16'h0);
    wr(2'd0, 16'h2000);
    chk("R9 unblocked", {15'b0, nmi_accept}, 16'h1);
    standby = 1'b1;
    #1;
    chk("R10 standby", {15'b0, nmi_accept}, 16'h0);
    standby = 1'b0; cpu_block = 1'b0;

    // Random trials across R3 R6 R7 R8 R9 R10
    for (int t = 0; t < 80; t++) begin
      ctrl = {3'($urandom), 13'b0};
      trig = 12'($urandom);
      oldp = 6'($urandom);
      newp = 6'($urandom);
      wr(2'd0, ctrl);
      wr(2'd1, {4'b0, trig});
      nmi_pin = 1'($urandom);
      cpu_block = 1'($urandom);
      standby = 1'($urandom);
      irq_pin = oldp;
      wait_n(4);
      wr(2'd2, 16'h003F);
      irq_pin = newp;
      wait_n(4);
      chk("R3 R6 R7 random pend", {10'b0, irq_pend},
          {10'b0, exp_pend(ctrl, trig, oldp, newp, nmi_pin)});
      ec = exp_code(ctrl, newp, nmi_pin);
      chk("R7 R8 random code", {11'b0, irq_lvl_vld, irq_lvl}, {11'b0, ec});
      chk("R9 R10 random nmi", {15'b0, nmi_accept},
          {15'b0, exp_nmi(ctrl, nmi_pin, cpu_block, standby)});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule